// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

This block is a watchdog counter whose configuration is guarded by a key-write state machine. After reset the watchdog is idle and software may freely set the counter, the period and the enable bit through a simple register-write port. To arm the watchdog, software writes the control word with the enable bit set and the 16-bit arming key. This moves the block to a pre-active state. A second write carrying the service key then clears the counter and starts it counting.

While the block is active the counter advances by one each clock. Software must service it with the arming key followed by the service key. The service key clears the counter only when an arming key came before it. If the counter reaches the period, the block enters a timeout state and raises a timeout flag that only a hardware reset clears. Once the block is armed, the counter and period registers are locked and the enable bit cannot be cleared. Only the key field of the control word still has any effect.

The write port selects a target with `wr_sel`: 0 is the control word, 1 is the counter, 2 is the period, and 3 is ignored. In the control word, bit 0 is the enable bit and bits 31:16 are the key field. The register contents are visible directly on the output ports.

Top module: `wdg_keyed_top`

## Requirements
- R1: After reset, the state is Initial (`state_o`=0), `enable_o`=0, the count is 0, the period is FFFFFFFFh and `timeout_o`=0. In Initial, writes to the counter (`wr_sel`=1) and period (`wr_sel`=2) take effect. A control write (`wr_sel`=0) loads `enable_o` from bit 0. The counter does not run.
- R2: A control write in Initial with bit 0 set and key A5C6h (bits 31:16) moves the state to Pre-active (`state_o`=1). The same key with bit 0 clear leaves the state in Initial.
- R3: In Pre-active, a control write with key DA7Eh clears the count and moves the state to Active (`state_o`=2).
- R4: In Active, a control write with key A5C6h marks a service as pending. A later control write with key DA7Eh then clears the count to 0 and consumes the pending mark.
- R5: From Pre-active onward, counter and period writes are ignored and `enable_o` stays 1 whatever bit 0 carries. Control writes with keys other than A5C6h and DA7Eh change nothing. In Pre-active the count holds its value.
- R6: In Active, a DA7Eh write without a pending A5C6h does not clear the count.
- R7: In Active, the count rises by exactly one per clock cycle.
- R8: In Active, when the count equals the period at a clock edge and no service happens in that cycle, the state becomes Timeout (`state_o`=3). At the same edge `timeout_o` goes to 1 and stays there until reset, and the count freezes.
- R9: In Timeout, control writes of any key or enable value have no effect.
- R10: If a valid service (DA7Eh with an A5C6h pending) arrives in the same cycle as a count/period match, the service wins: the count clears and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 counter, 2 period, 3 none |
| wr_data | input | 32 | Write data; control word uses bit 0 enable, bits 31:16 key |
| state_o | output | 2 | Key state: 0 Initial, 1 Pre-active, 2 Active, 3 Timeout |
| enable_o | output | 1 | Stored enable bit |
| count_o | output | 32 | Current counter value |
| period_o | output | 32 | Current period value |
| timeout_o | output | 1 | Sticky timeout flag |

## Verification
The hardest case to reach from the ports is a valid service that lands in exactly the cycle where the count equals the period. Only that timing shows whether the service or the timeout takes priority. The stimulus arms a pending service, then steps idle cycles while its own model tracks the count. It issues the service key on the cycle in which the modelled count matches the period. A second reset with a period of zero covers the case where the timeout occurs on the very first active cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    WDG_INIT    = 2'd0,
    WDG_PRE     = 2'd1,
    WDG_ACTIVE  = 2'd2,
    WDG_TIMEOUT = 2'd3
  } wdg_state_e;

  localparam logic [1:0] SEL_CTRL   = 2'd0;
  localparam logic [1:0] SEL_COUNT  = 2'd1;
  localparam logic [1:0] SEL_PERIOD = 2'd2;

  function automatic logic [31:0] count_step(input logic [31:0] cur);
    return cur + 32'd1;
  endfunction

  function automatic logic key_is(input logic [15:0] key, input logic [15:0] ref_key);
    return key == ref_key;
  endfunction
endpackage

// File: rtl/wdg_counter.sv
module wdg_counter
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_cnt_i,
  input  logic             wr_per_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             unlocked_i,
  input  logic             run_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] period_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q, per_q;
  logic             cnt_wr_ok, per_wr_ok, step_en;

  assign cnt_wr_ok = wr_cnt_i && unlocked_i;
  assign per_wr_ok = wr_per_i && unlocked_i;
  assign hit_o     = (cnt_q == per_q);
  assign step_en   = run_i && !hit_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_wr_ok) begin
      cnt_q <= wr_data_i;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (step_en) begin
      cnt_q <= CNT_W'(count_step(32'(cnt_q)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) per_q <= '1;
    else if (per_wr_ok) per_q <= wr_data_i;
  end

  assign count_o  = cnt_q;
  assign period_o = per_q;

  // R4
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !cnt_wr_ok) |=> (cnt_q == '0));
  // R7
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !clr_i && !cnt_wr_ok) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R5
  period_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_i |=> $stable(per_q));
endmodule

// File: rtl/wdg_key_fsm.sv
module wdg_key_fsm
  import wdg_pkg::*;
#(
  parameter int              KEY_W   = 16,
  parameter logic [KEY_W-1:0] ARM_KEY = 16'hA5C6,
  parameter logic [KEY_W-1:0] SVC_KEY = 16'hDA7E
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             en_bit_i,
  input  logic             hit_i,
  output wdg_state_e       state_o,
  output logic             enable_o,
  output logic             run_o,
  output logic             clr_o,
  output logic             svc_fire_o
);
  wdg_state_e state_q, state_n;
  logic       en_q, en_n, pend_q, pend_n;
  logic       key_arm, key_svc, go_active, go_timeout;

  assign key_arm = ctrl_wr_i && key_is(16'(key_i), 16'(ARM_KEY));
  assign key_svc = ctrl_wr_i && key_is(16'(key_i), 16'(SVC_KEY));

  always_comb begin
    state_n    = state_q;
    en_n       = en_q;
    pend_n     = pend_q;
    svc_fire_o = 1'b0;
    go_active  = 1'b0;
    go_timeout = 1'b0;
    unique case (state_q)
      WDG_INIT: begin
        if (ctrl_wr_i) en_n = en_bit_i;
        if (key_arm && en_bit_i) state_n = WDG_PRE;
      end
      WDG_PRE: begin
        if (key_svc && en_q) begin
          go_active = 1'b1;
          state_n   = WDG_ACTIVE;
          pend_n    = 1'b0;
        end
      end
      WDG_ACTIVE: begin
        svc_fire_o = key_svc && pend_q;
        if (key_arm) pend_n = 1'b1;
        if (svc_fire_o) pend_n = 1'b0;
        if (hit_i && !svc_fire_o) begin
          go_timeout = 1'b1;
          state_n    = WDG_TIMEOUT;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WDG_INIT;
      en_q    <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      en_q    <= en_n;
      pend_q  <= pend_n;
    end
  end

  assign state_o  = state_q;
  assign enable_o = en_q;
  assign run_o    = (state_q == WDG_ACTIVE);
  assign clr_o    = go_active || svc_fire_o;

  // R8
  timeout_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == WDG_TIMEOUT) |=> (state_q == WDG_TIMEOUT));
  // R5
  enable_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != WDG_INIT) |-> en_q);
  // R8
  match_to_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && hit_i && !svc_fire_o) |=> (state_q == WDG_TIMEOUT));
  // R10
  service_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o && svc_fire_o) |=> (state_q == WDG_ACTIVE));
  // R2
  arm_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == WDG_PRE) && ($past(state_q) == WDG_INIT)) |-> en_q);
endmodule

// File: rtl/wdg_keyed_top.sv
module wdg_keyed_top
  import wdg_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int KEY_W   = 16,
  parameter int KEY_LSB = 16,
  parameter int EN_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [1:0]       state_o,
  output logic             enable_o,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] period_o,
  output logic             timeout_o
);
  localparam int KEY_MSB = KEY_LSB + KEY_W - 1;

  wdg_state_e       state;
  logic             ctrl_wr, cnt_wr, per_wr, unlocked;
  logic             run, clr, hit, svc_fire;
  logic [KEY_W-1:0] key_field;

  assign ctrl_wr   = wr_en && (wr_sel == SEL_CTRL);
  assign cnt_wr    = wr_en && (wr_sel == SEL_COUNT);
  assign per_wr    = wr_en && (wr_sel == SEL_PERIOD);
  assign key_field = wr_data[KEY_MSB:KEY_LSB];
  assign unlocked  = (state == WDG_INIT);

  wdg_key_fsm #(.KEY_W(KEY_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr_i  (ctrl_wr),
    .key_i      (key_field),
    .en_bit_i   (wr_data[EN_BIT]),
    .hit_i      (hit),
    .state_o    (state),
    .enable_o   (enable_o),
    .run_o      (run),
    .clr_o      (clr),
    .svc_fire_o (svc_fire)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_cnt_i   (cnt_wr),
    .wr_per_i   (per_wr),
    .wr_data_i  (wr_data),
    .unlocked_i (unlocked),
    .run_i      (run),
    .clr_i      (clr),
    .count_o    (count_o),
    .period_o   (period_o),
    .hit_o      (hit)
  );

  assign state_o   = state;
  assign timeout_o = (state == WDG_TIMEOUT);

  // R9
  timeout_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> ($stable(count_o) && timeout_o && enable_o));
  // R6
  svc_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctrl_wr && (key_field == 16'hDA7E) && !svc_fire && !hit) |=> (count_o != '0));
endmodule

// File: tb/wdg_keyed_top_tb_top.sv
`timescale 1ns/1ps
module wdg_keyed_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd3;
  logic [31:0] wr_data = '0;
  logic [1:0]  state_o;
  logic        enable_o, timeout_o;
  logic [31:0] count_o, period_o;

  wdg_keyed_top dut_i (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    logic [1:0]  st;
    logic        en;
    logic [31:0] cnt;
    logic [31:0] per;
    logic        to;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [1:0]  m_st;
  logic        m_en, m_pend;
  logic [31:0] m_cnt, m_per;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic model_reset();
    m_st = 2'd0; m_en = 0; m_pend = 0; m_cnt = '0; m_per = '1;
  endtask

  task automatic step(input bit we, input logic [1:0] sel, input logic [31:0] d, input string tag);
    logic [15:0] k;
    bit svc;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d;
    k = d[31:16];
    case (m_st)
      2'd0: begin
        if (we && sel == 2'd1) m_cnt = d;
        if (we && sel == 2'd2) m_per = d;
        if (we && sel == 2'd0) begin
          m_en = d[0];
          if (k == 16'hA5C6 && d[0]) m_st = 2'd1;
        end
      end
      2'd1: if (we && sel == 2'd0 && k == 16'hDA7E) begin
        m_st = 2'd2; m_cnt = '0; m_pend = 0;
      end
      2'd2: begin
        svc = we && sel == 2'd0 && k == 16'hDA7E && m_pend;
        if (svc) begin m_cnt = '0; m_pend = 0; end
        else if (m_cnt == m_per) m_st = 2'd3;
        else m_cnt = m_cnt + 1;
        if (we && sel == 2'd0 && k == 16'hA5C6) m_pend = 1;
      end
      default: ;
    endcase
    exp_q.push_back('{m_st, m_en, m_cnt, m_per, (m_st == 2'd3), tag});
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 2'd3, '0, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0;
    model_reset();
    @(negedge clk);
    @(negedge clk);
    // R1 reset state
    check(state_o == 2'd0, "R1", "state", 32'(state_o), 0);
    check(enable_o == 0 && timeout_o == 0, "R1", "en/to", {enable_o, timeout_o}, 0);
    check(count_o == 0, "R1", "count", count_o, 0);
    check(period_o == '1, "R1", "period", period_o, '1);
    rst_n = 1;
  endtask

  // monitor: compare each expected item one edge after it was driven
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(state_o == e.st, e.tag, "state", 32'(state_o), 32'(e.st));
      check(enable_o == e.en, e.tag, "enable", 32'(enable_o), 32'(e.en));
      check(count_o == e.cnt, e.tag, "count", count_o, e.cnt);
      check(period_o == e.per, e.tag, "period", period_o, e.per);
      check(timeout_o == e.to, e.tag, "timeout", 32'(timeout_o), 32'(e.to));
    end
  end

  initial begin
    model_reset();
    do_reset();
    // R1 free writes in Initial
    step(1, 2'd1, 32'd5, "R1");
    step(1, 2'd2, 32'd20, "R1");
    step(1, 2'd0, 32'h0000_0001, "R1");
    step(1, 2'd0, 32'h0000_0000, "R1");
    idle(2, "R1");
    // R2 key without enable bit stays Initial
    step(1, 2'd0, 32'hA5C6_0000, "R2");
    step(1, 2'd0, 32'hA5C6_0001, "R2");
    // R5 locked writes in Pre-active
    step(1, 2'd1, 32'd99, "R5");
    step(1, 2'd2, 32'd7, "R5");
    step(1, 2'd0, 32'h1234_0000, "R5");
    step(1, 2'd0, 32'hA5C6_0000, "R5");
    idle(2, "R5");
    // R3 activation
    step(1, 2'd0, 32'hDA7E_0000, "R3");
    // R7 counting
    idle(4, "R7");
    // R6 lone service key
    step(1, 2'd0, 32'hDA7E_0000, "R6");
    idle(1, "R6");
    // R4 proper service
    step(1, 2'd0, 32'hA5C6_0000, "R4");
    idle(2, "R4");
    step(1, 2'd0, 32'hDA7E_0000, "R4");
    idle(3, "R7");
    // R10 service in the match cycle
    step(1, 2'd0, 32'hA5C6_0001, "R10");
    while (m_cnt != m_per) step(0, 2'd3, '0, "R10");
    step(1, 2'd0, 32'hDA7E_0000, "R10");
    // R8 run to timeout
    while (m_st != 2'd3) step(0, 2'd3, '0, "R8");
    idle(3, "R8");
    // R9 writes in Timeout
    step(1, 2'd0, 32'hA5C6_0000, "R9");
    step(1, 2'd0, 32'hDA7E_0000, "R9");
    step(1, 2'd1, 32'd0, "R9");
    idle(2, "R9");
    // R8 boundary: period zero times out on the first active cycle
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    do_reset();
    step(1, 2'd2, 32'd0, "R8");
    step(1, 2'd0, 32'hA5C6_0001, "R2");
    step(1, 2'd0, 32'hDA7E_0001, "R3");
    idle(3, "R8");
    @(negedge clk);
    while (exp_q.size() > 0) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule